// File: doc/BRIEF.md
# Transmit Packet Start Controller

This block holds transmit packet words in a local store and decides when the line side may begin pulling a new packet out of it. A writer pushes words tagged with an end-of-packet flag. While waiting for a new packet, the block checks two things: the number of stored words, and whether at least one complete packet is stored. In the default mode a packet is released once either test passes. In the threshold-only mode it is released only when the word count reaches the programmed minimum.

Once a packet is released, words flow on every line-side request until the end-of-packet word leaves the store, and the threshold is not checked again. If the line side asks for a word while the store is empty in the middle of a packet, the block signals an abort. Every word still arriving for that packet is then thrown away. Transmission resumes only after the store refills to a restart level of 16N+1 words.

A registered space-available flag is sent back to the writer. It is either driven all the time or answered only when the writer polls for it. The start mode, minimum level and restart step are sampled only while the controller is idle between packets.

Top module: `tx_start_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, `pkt_start`, `pkt_abort`, `rd_valid`, `rd_eop`, `wr_full` and `fa_out` are all 0, and the store is empty.
- R2: With `cfg_min_only`=0, `pkt_start` is raised combinationally in the waiting state when the store holds at least one end-of-packet word, or holds a nonzero count of words that is at least `cfg_min_lvl`.
- R3: With `cfg_min_only`=1, `pkt_start` is raised only when the stored count is nonzero and at least `cfg_min_lvl`, even if a complete packet is stored.
- R4: After a start, each cycle with `rd_req`=1 and a non-empty store gives `rd_valid`=1 together with the oldest word and its end flag on `rd_data`/`rd_eop`, with no threshold check. Reading the end-flagged word returns the controller to idle for one cycle and then to waiting.
- R5: A cycle with `rd_req`=1, an active packet and an empty store gives a one-cycle `pkt_abort`=1 with `rd_valid`=0.
- R6: Writes in the abort cycle and afterwards are dropped, up to and including the next write with `wr_eop`=1.
- R7: After an abort, no packet starts until discarding has ended and the count reaches 16N+1. N is `cfg_restart_n`; with `SINGLE_CHAN`=0 only its low four bits count (N 0..15), with `SINGLE_CHAN`=1 all six bits count (N 0..63).
- R8: `cfg_min_only`, `cfg_min_lvl` and `cfg_restart_n` are captured only in the idle state; changes made at other times have no effect until the next idle cycle.
- R9: `fa_out` is registered from the stored count before the clock edge, and is 1 when free space is at least `FA_SPACE`. With `cfg_fa_polled`=1 it is also 0 unless `fa_poll` was 1 in the previous cycle.
- R10: `wr_full`=1 when the store holds `DEPTH` words, and a write in such a cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_min_only | input | 1 | 1 = start on threshold only, 0 = threshold or complete packet |
| cfg_min_lvl | input | CNT_W | Minimum word count for starting a packet |
| cfg_restart_n | input | 6 | Restart step N, level 16N+1 |
| cfg_fa_polled | input | 1 | 1 = space flag answers polls only |
| fa_poll | input | 1 | Poll request for the space flag |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write word |
| wr_eop | input | 1 | Write word ends a packet |
| wr_full | output | 1 | Store is full |
| rd_req | input | 1 | Line side requests a word |
| rd_valid | output | 1 | Word delivered this cycle |
| rd_data | output | DATA_W | Delivered word |
| rd_eop | output | 1 | Delivered word ends a packet |
| pkt_start | output | 1 | Packet released this cycle |
| pkt_abort | output | 1 | Underflow abort this cycle |
| fa_out | output | 1 | Space-available flag |

## Verification
The assertions assume that the line side requests words only through `rd_req`, that `cfg_min_lvl` fits the store depth, and that configuration inputs are plain levels with no relation to the handshake. The stimulus holds each input steady from just after one rising edge to the next, and changes configuration only at chosen points: some fall inside the idle window and some deliberately fall outside it. Underflow is produced on purpose by requesting past the last stored word of a packet that has no end flag yet, and the later words of that packet are then written so that the discard path is exercised.

// File: rtl/txs_pkg.sv
package txs_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_SEND = 2'd2,
      ST_HOLD = 2'd3
   } txs_state_e;
endpackage

// File: rtl/txs_store.sv
module txs_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 256,
   localparam int AW    = $clog2(DEPTH),
   localparam int CNT_W = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              push_eop,
   input  logic              pop,
   output logic [DATA_W-1:0] head_data,
   output logic              head_eop,
   output logic [CNT_W-1:0]  level,
   output logic [CNT_W-1:0]  eop_level
);
   logic [DATA_W:0]  mem [DEPTH];
   logic [AW-1:0]    wptr_q, rptr_q;
   logic [CNT_W-1:0] level_q, eop_q;
   logic             eop_in, eop_out;

   assign {head_eop, head_data} = mem[rptr_q];
   assign level     = level_q;
   assign eop_level = eop_q;
   assign eop_in    = push & push_eop;
   assign eop_out   = pop & head_eop;

   always_ff @(posedge clk) begin
      if (push) mem[wptr_q] <= {push_eop, push_data};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr_q  <= '0;
         rptr_q  <= '0;
         level_q <= '0;
         eop_q   <= '0;
      end else begin
         if (push) wptr_q <= wptr_q + 1'b1;
         if (pop)  rptr_q <= rptr_q + 1'b1;
         case ({push, pop})
            2'b10:   level_q <= level_q + 1'b1;
            2'b01:   level_q <= level_q - 1'b1;
            default: level_q <= level_q;
         endcase
         case ({eop_in, eop_out})
            2'b10:   eop_q <= eop_q + 1'b1;
            2'b01:   eop_q <= eop_q - 1'b1;
            default: eop_q <= eop_q;
         endcase
      end
   end

   // R4
   pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> level_q != '0);
   // R10
   push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> level_q != CNT_W'(DEPTH));
   // R10
   level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      level_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/txs_start_fsm.sv
module txs_start_fsm
   import txs_pkg::*;
#(
   parameter int DEPTH       = 256,
   parameter bit SINGLE_CHAN = 1'b0,
   localparam int CNT_W      = $clog2(DEPTH) + 1,
   localparam logic [5:0] N_MASK = SINGLE_CHAN ? 6'h3F : 6'h0F
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_min_only,
   input  logic [CNT_W-1:0] cfg_min_lvl,
   input  logic [5:0]       cfg_restart_n,
   input  logic [CNT_W-1:0] level,
   input  logic [CNT_W-1:0] eop_level,
   input  logic             head_eop,
   input  logic             rd_req,
   input  logic             wr_en,
   input  logic             wr_eop,
   output txs_state_e       state,
   output logic             pkt_start,
   output logic             pkt_abort,
   output logic             pop,
   output logic             push
);
   txs_state_e       state_q, state_d;
   logic             min_only_q;
   logic [CNT_W-1:0] min_lvl_q, restart_lvl_q, restart_lvl_w;
   logic [5:0]       n_eff;
   logic             discard_q, discard_d;
   logic             nonempty, full, lvl_ok, drop;

   assign n_eff         = cfg_restart_n & N_MASK;
   assign restart_lvl_w = CNT_W'({n_eff, 4'b0001});

   assign nonempty  = level != '0;
   assign full      = level == CNT_W'(DEPTH);
   assign lvl_ok    = nonempty && (level >= min_lvl_q);
   assign pkt_start = (state_q == ST_WAIT) &&
                      (lvl_ok || (!min_only_q && eop_level != '0));
   assign pop       = (state_q == ST_SEND) && rd_req && nonempty;
   assign pkt_abort = (state_q == ST_SEND) && rd_req && !nonempty;
   assign drop      = discard_q || pkt_abort;
   assign push      = wr_en && !drop && !full;
   assign state     = state_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: state_d = ST_WAIT;
         ST_WAIT: if (pkt_start) state_d = ST_SEND;
         ST_SEND: begin
            if (pop && head_eop)  state_d = ST_IDLE;
            else if (pkt_abort)   state_d = ST_HOLD;
         end
         ST_HOLD: if (!discard_q && level >= restart_lvl_q) state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_comb begin
      discard_d = discard_q;
      if (pkt_abort)                          discard_d = !(wr_en && wr_eop);
      else if (discard_q && wr_en && wr_eop)  discard_d = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q       <= ST_IDLE;
         discard_q     <= 1'b0;
         min_only_q    <= 1'b0;
         min_lvl_q     <= '0;
         restart_lvl_q <= CNT_W'(1);
      end else begin
         state_q   <= state_d;
         discard_q <= discard_d;
         if (state_q == ST_IDLE) begin
            min_only_q    <= cfg_min_only;
            min_lvl_q     <= cfg_min_lvl;
            restart_lvl_q <= restart_lvl_w;
         end
      end
   end

   // R2
   start_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_start |-> level != '0);
   // R5
   abort_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_abort |=> !pkt_start && !pop);
   // R6
   discard_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (discard_q && wr_en) |-> !push);
   // R7
   hold_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HOLD) |=> !pkt_start);
   // R8
   shadow_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |=> $stable(min_lvl_q) && $stable(min_only_q) && $stable(restart_lvl_q));
endmodule

// File: rtl/txs_fa_status.sv
module txs_fa_status #(
   parameter int DEPTH    = 256,
   parameter int FA_SPACE = 16,
   localparam int CNT_W   = $clog2(DEPTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] level,
   input  logic             polled,
   input  logic             poll,
   output logic             fa
);
   logic room, fa_q;

   assign room = (CNT_W'(DEPTH) - level) >= CNT_W'(FA_SPACE);
   assign fa   = fa_q;

   always_ff @(posedge clk) begin
      if (!rst_n) fa_q <= 1'b0;
      else        fa_q <= room && (!polled || poll);
   end

   // R9
   poll_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (polled && !poll) |=> !fa);
endmodule

// File: rtl/tx_start_ctrl.sv
module tx_start_ctrl
   import txs_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int DEPTH       = 256,
   parameter bit SINGLE_CHAN = 1'b0,
   parameter int FA_SPACE    = 16,
   localparam int CNT_W      = $clog2(DEPTH) + 1,
   localparam int N_MAX      = SINGLE_CHAN ? 63 : 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_min_only,
   input  logic [CNT_W-1:0]  cfg_min_lvl,
   input  logic [5:0]        cfg_restart_n,
   input  logic              cfg_fa_polled,
   input  logic              fa_poll,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_eop,
   output logic              wr_full,
   input  logic              rd_req,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_eop,
   output logic              pkt_start,
   output logic              pkt_abort,
   output logic              fa_out
);
   generate
      if ((1 << $clog2(DEPTH)) != DEPTH) begin : g_bad_depth
         $error("DEPTH must be a power of two");
      end
      if (DEPTH < 16 * N_MAX + 1) begin : g_bad_restart
         $error("DEPTH too small for the largest restart level");
      end
      if (FA_SPACE < 1 || FA_SPACE > DEPTH) begin : g_bad_space
         $error("FA_SPACE out of range");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be positive");
      end
   endgenerate

   txs_state_e        state;
   logic              push, pop, head_eop;
   logic [DATA_W-1:0] head_data;
   logic [CNT_W-1:0]  level, eop_level;

   txs_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n),
      .push(push), .push_data(wr_data), .push_eop(wr_eop),
      .pop(pop),
      .head_data(head_data), .head_eop(head_eop),
      .level(level), .eop_level(eop_level)
   );

   txs_start_fsm #(.DEPTH(DEPTH), .SINGLE_CHAN(SINGLE_CHAN)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .cfg_min_only(cfg_min_only), .cfg_min_lvl(cfg_min_lvl),
      .cfg_restart_n(cfg_restart_n),
      .level(level), .eop_level(eop_level), .head_eop(head_eop),
      .rd_req(rd_req), .wr_en(wr_en), .wr_eop(wr_eop),
      .state(state), .pkt_start(pkt_start), .pkt_abort(pkt_abort),
      .pop(pop), .push(push)
   );

   txs_fa_status #(.DEPTH(DEPTH), .FA_SPACE(FA_SPACE)) u_fa (
      .clk(clk), .rst_n(rst_n),
      .level(level), .polled(cfg_fa_polled), .poll(fa_poll),
      .fa(fa_out)
   );

   assign wr_full  = level == CNT_W'(DEPTH);
   assign rd_valid = pop;
   assign rd_data  = pop ? head_data : '0;
   assign rd_eop   = pop & head_eop;

   // R4
   valid_only_sending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> state == ST_SEND);
   // R5
   abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({rd_valid, pkt_abort, pkt_start}) <= 1);
endmodule

// File: tb/sim_tx_start_ctrl.sv
module sim_tx_start_ctrl;
   localparam int CLK_NS = 10;
   localparam int DW     = 8;
   localparam int DEPTH  = 256;
   localparam int CW     = $clog2(DEPTH) + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_min_only = 1'b0;
   logic [CW-1:0] cfg_min_lvl = '0;
   logic [5:0]    cfg_restart_n = '0;
   logic          cfg_fa_polled = 1'b0;
   logic          fa_poll = 1'b0;
   logic          wr_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          wr_eop = 1'b0;
   logic          rd_req = 1'b0;
   logic          wr_full, rd_valid, rd_eop, pkt_start, pkt_abort, fa_out;
   logic [DW-1:0] rd_data;

   tx_start_ctrl #(.DATA_W(DW), .DEPTH(DEPTH), .SINGLE_CHAN(1'b0), .FA_SPACE(16)) u0 (
      .clk(clk), .rst_n(rst_n),
      .cfg_min_only(cfg_min_only), .cfg_min_lvl(cfg_min_lvl),
      .cfg_restart_n(cfg_restart_n), .cfg_fa_polled(cfg_fa_polled),
      .fa_poll(fa_poll), .wr_en(wr_en), .wr_data(wr_data), .wr_eop(wr_eop),
      .wr_full(wr_full), .rd_req(rd_req), .rd_valid(rd_valid),
      .rd_data(rd_data), .rd_eop(rd_eop), .pkt_start(pkt_start),
      .pkt_abort(pkt_abort), .fa_out(fa_out)
   );

   always #(CLK_NS/2) clk = ~clk;

   int n_cmp = 0;
   int n_bad = 0;
   int starts = 0;
   int aborts = 0;
   int first_after_abort = -1;
   bit armed = 1'b0;
   bit done = 1'b0;

   // reference model state
   int         ms = 0;
   logic [8:0] mq[$];
   bit         m_mode = 0;
   int         m_min = 0;
   int         m_rl = 1;
   bit         m_disc = 0;
   bit         m_fa = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input int d, input bit e);
      wr_en = 1'b1; wr_data = DW'(d); wr_eop = e;
      tick();
      wr_en = 1'b0; wr_eop = 1'b0;
   endtask

   always @(negedge clk) begin
      int cnt, eopn, nxt;
      bit e_start, e_valid, e_abort, e_full, drop, disc_n, fa_n;
      logic [8:0] tmp;
      if (!done) begin
         cnt = mq.size();
         eopn = 0;
         foreach (mq[i]) if (mq[i][8]) eopn++;
         e_start = (ms == 1) && ((cnt != 0 && cnt >= m_min) || (!m_mode && eopn != 0));
         e_valid = (ms == 2) && rd_req && cnt != 0;
         e_abort = (ms == 2) && rd_req && cnt == 0;
         e_full  = cnt == DEPTH;
         chk(pkt_start == e_start, "R2/R3 pkt_start", pkt_start, e_start);
         chk(rd_valid == e_valid, "R4 rd_valid", rd_valid, e_valid);
         chk(rd_eop == (e_valid && mq[0][8]), "R4 rd_eop", rd_eop, e_valid && mq[0][8]);
         if (e_valid) chk(rd_data == mq[0][7:0], "R4/R6 rd_data", rd_data, mq[0][7:0]);
         chk(pkt_abort == e_abort, "R5 pkt_abort", pkt_abort, e_abort);
         chk(wr_full == e_full, "R10 wr_full", wr_full, e_full);
         chk(fa_out == m_fa, "R9 fa_out", fa_out, m_fa);
         if (pkt_start) starts++;
         if (pkt_abort) begin aborts++; armed = 1'b1; end
         if (rd_valid && armed) begin first_after_abort = rd_data; armed = 1'b0; end
         if (!rst_n) begin
            ms = 0; mq.delete(); m_mode = 0; m_min = 0; m_rl = 1; m_disc = 0; m_fa = 0;
         end else begin
            nxt = ms;
            disc_n = m_disc;
            case (ms)
               0: begin
                  nxt = 1; m_mode = cfg_min_only; m_min = cfg_min_lvl;
                  m_rl = 16 * (cfg_restart_n % 16) + 1;
               end
               1: if (e_start) nxt = 2;
               2: if (e_valid) begin if (mq[0][8]) nxt = 0; end
                  else if (e_abort) nxt = 3;
               default: if (!m_disc && cnt >= m_rl) nxt = 0;
            endcase
            fa_n = ((DEPTH - cnt) >= 16) && (!cfg_fa_polled || fa_poll);
            if (e_valid) tmp = mq.pop_front();
            drop = m_disc || e_abort;
            if (wr_en && !drop && cnt != DEPTH) mq.push_back({wr_eop, wr_data});
            if (e_abort) disc_n = !(wr_en && wr_eop);
            else if (m_disc && wr_en && wr_eop) disc_n = 0;
            m_disc = disc_n;
            m_fa = fa_n;
            ms = nxt;
         end
      end
   end

   task automatic finish_run();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(CLK_NS * 20000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      int s0;
      cfg_min_lvl = CW'(8);
      cfg_restart_n = 6'b010001;   // R7: quad mode uses N=1 -> 17 words
      repeat (3) tick();
      @(negedge clk);
      // R1 reset state
      chk(!pkt_start && !pkt_abort && !rd_valid, "R1 handshake idle", {pkt_start, pkt_abort, rd_valid}, 0);
      chk(!wr_full && !fa_out, "R1 status idle", {wr_full, fa_out}, 0);
      rst_n = 1'b1;
      tick();

      // R2: complete packet below the threshold starts
      s0 = starts;
      wr(1, 0); wr(2, 0); wr(3, 1);
      repeat (3) tick();
      chk(starts == s0 + 1, "R2 eop start", starts - s0, 1);
      rd_req = 1'b1; repeat (6) tick(); rd_req = 1'b0;

      // R8: config changed while waiting is ignored; R2 threshold start
      cfg_min_only = 1'b1; cfg_min_lvl = CW'(100);
      s0 = starts;
      for (int i = 0; i < 10; i++) wr(10 + i, 0);
      repeat (2) tick();
      chk(starts == s0 + 1, "R8 old cfg kept", starts - s0, 1);
      cfg_min_only = 1'b0; cfg_min_lvl = CW'(8);

      // R5 underflow
      rd_req = 1'b1; repeat (12) tick(); rd_req = 1'b0;
      chk(aborts == 1, "R5 abort count", aborts, 1);

      // R6 remainder discarded; R7 hold until 17 words
      for (int i = 0; i < 4; i++) wr(100 + i, i == 3);
      s0 = starts;
      for (int i = 0; i < 5; i++) wr(40 + i, i == 4);
      repeat (3) tick();
      chk(starts == s0, "R7 held below restart", starts - s0, 0);
      cfg_min_only = 1'b1; cfg_min_lvl = CW'(6);
      for (int i = 0; i < 12; i++) wr(50 + i, i == 11);
      repeat (3) tick();
      chk(starts == s0 + 1, "R7 restart reached", starts - s0, 1);
      rd_req = 1'b1; repeat (25) tick(); rd_req = 1'b0;
      chk(first_after_abort == 40, "R6 first word after abort", first_after_abort, 40);

      // R3 threshold-only mode
      s0 = starts;
      wr(70, 0); wr(71, 0); wr(72, 1);
      repeat (3) tick();
      chk(starts == s0, "R3 eop ignored", starts - s0, 0);
      wr(73, 0); wr(74, 0); wr(75, 0);
      repeat (2) tick();
      chk(starts == s0 + 1, "R3 threshold start", starts - s0, 1);
      cfg_min_lvl = CW'(511); cfg_fa_polled = 1'b1; fa_poll = 1'b0;
      rd_req = 1'b1; repeat (4) tick(); rd_req = 1'b0;

      // R9 polled flag
      fa_poll = 1'b1; tick(); fa_poll = 1'b0;
      @(negedge clk);
      chk(fa_out == 1'b1, "R9 poll answered", fa_out, 1);
      tick();
      @(negedge clk);
      chk(fa_out == 1'b0, "R9 quiet without poll", fa_out, 0);

      // R10 fill to full, extra writes dropped
      for (int i = 0; i < 260; i++) wr(i, 0);
      @(negedge clk);
      chk(wr_full == 1'b1, "R10 full", wr_full, 1);
      fa_poll = 1'b1; tick(); fa_poll = 1'b0;
      @(negedge clk);
      chk(fa_out == 1'b0, "R9 no room", fa_out, 0);
      tick();
      finish_run();
   end
endmodule